// File: doc/BRIEF.md
# Instruction Boundary Marker for a 16-bit Parcel Stream

This block sits in an instruction front end that fetches a fixed line of sixteen 16-bit parcels per cycle. For every parcel position it decides whether an instruction begins there and, if so, how long that instruction is. It also reports how many instructions finish inside the line. The length of an instruction is fixed entirely by its first parcel: the count of consecutive one bits from bit 0 upward selects 16, 32, 48 or 64 bits, or a reserved code.

Instructions may straddle two lines. The block keeps only the number of parcels the straddling instruction still needs. On the next line it skips those parcels and reports how many it skipped. A redirect flag sent with a line drops any pending straddle and starts the scan at a given parcel offset inside that line. Lines enter through a valid/ready handshake. Results leave through a registered valid/ready stage one cycle later.

Top module: `vl_boundary_marker`

## Requirements
- R1: For each start parcel, the run of ones counted from bit 0 over bits 6:0 sets its length code (3 bits, field i at out_len[3i+2:3i]). A run of 0 or 1 gives code 0 (one parcel). A run of 2, 3 or 4 gives code 1 (two parcels). A run of 5 gives code 2 (three parcels), and a run of 6 gives code 3 (four parcels). A run of 7 gives code 4, reserved, which occupies one parcel so the scan resumes at the next one.
- R2: With no pending straddle and no redirect, parcel 0 is a start. Every later start sits directly after the last parcel of the instruction before it.
- R3: out_start bit i is 1 exactly when parcel i begins an instruction. The length field of every non-start parcel is 0.
- R4: out_count equals the number of instructions whose last parcel lies in the line. An instruction carried in from the previous line counts here, and a reserved code counts as one instruction.
- R5: When an instruction from the previous line is still missing k parcels (1 to 3), the next line's parcels 0 to k-1 are not starts, out_tail equals k, and parcel k is a start.
- R6: A line accepted with in_flush high drops any pending straddle and reports out_tail = 0. Parcels below in_offset are not starts, and parcel in_offset is a start.
- R7: in_ready is high when no result is held or out_ready is high. A line is taken only when in_valid and in_ready are both high. While out_valid is high and out_ready is low, all outputs stay unchanged.
- R8: After reset out_valid is 0, in_ready is 1, and no straddle is pending.
- R9: A line accepted on a clock edge produces out_valid high with its results from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetch line is offered |
| in_ready | output | 1 | The block can take a line this cycle |
| in_line | input | PARCELS*PARCEL_W | Fetch line, parcel i at bits [16i+15:16i] |
| in_flush | input | 1 | Redirect: drop the straddle and start at in_offset |
| in_offset | input | log2(PARCELS) | First parcel to scan on a redirect line |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_start | output | PARCELS | One start flag per parcel |
| out_len | output | PARCELS*3 | Length code per parcel, 0 where no start |
| out_count | output | log2(PARCELS+1) | Instructions that end in this line |
| out_tail | output | 2 | Leading parcels that finish the carried instruction |

## Verification
The assertions assume the line sent with a redirect flag has a legal offset, which the port width guarantees. They also assume that on a line without a redirect, the parcels the straddle needs really are its continuation. The bench meets both conditions by building the whole stream from a list of instructions first and slicing it into lines afterwards. Parcels below a redirect offset are filled with all-ones junk, which would read as reserved starts if they were scanned. The redirect lines sweep every offset from 0 to 15, often while a straddle is still pending, and stalls are placed while the next line is already being offered.

// File: rtl/vlbm_pkg.sv
package vlbm_pkg;
    localparam int LEN_W     = 3;
    localparam int HEAD_BITS = 7;

    typedef enum logic [LEN_W-1:0] {
        LEN16   = 3'd0,
        LEN32   = 3'd1,
        LEN48   = 3'd2,
        LEN64   = 3'd3,
        LEN_RSV = 3'd4
    } len_code_e;
endpackage

// File: rtl/vlbm_parcel_len.sv
module vlbm_parcel_len #(
    parameter int PARCEL_W = 16
) (
    input  logic [PARCEL_W-1:0]          parcel,
    output logic [vlbm_pkg::LEN_W-1:0]   code,
    output logic [2:0]                   span
);
    import vlbm_pkg::*;

    logic [2:0] run_len;
    logic       run_on;
    logic       unused_upper;

    assign unused_upper = ^parcel[PARCEL_W-1:HEAD_BITS];

    // Trailing-ones count over the low bits of the parcel.
    always_comb begin
        run_len = '0;
        run_on  = 1'b1;
        for (int i = 0; i < HEAD_BITS; i++) begin
            if (run_on && parcel[i]) run_len = run_len + 3'd1;
            else                     run_on  = 1'b0;
        end
    end

    always_comb begin
        case (run_len)
            3'd0, 3'd1:       begin code = LEN16;   span = 3'd1; end
            3'd2, 3'd3, 3'd4: begin code = LEN32;   span = 3'd2; end
            3'd5:             begin code = LEN48;   span = 3'd3; end
            3'd6:             begin code = LEN64;   span = 3'd4; end
            default:          begin code = LEN_RSV; span = 3'd1; end
        endcase
    end
endmodule

// File: rtl/vlbm_scan.sv
module vlbm_scan #(
    parameter  int PARCELS = 16,
    localparam int IDX_W   = $clog2(PARCELS),
    localparam int REM_W   = IDX_W + 1,
    localparam int CNT_W   = $clog2(PARCELS + 1),
    localparam int LEN_W   = vlbm_pkg::LEN_W
) (
    input  logic [LEN_W-1:0]         code [PARCELS],
    input  logic [2:0]               span [PARCELS],
    input  logic [REM_W-1:0]         skip,
    output logic [PARCELS-1:0]       start,
    output logic [PARCELS*LEN_W-1:0] len,
    output logic [CNT_W-1:0]         done_cnt,
    output logic [1:0]               carry
);
    // rem[g] = parcels still to pass over before position g may start.
    logic [REM_W-1:0]   rem [PARCELS+1];
    logic [PARCELS-1:0] ends_here;
    logic               unused_rem;

    assign rem[0] = skip;

    for (genvar g = 0; g < PARCELS; g++) begin : g_chain
        assign start[g]   = (rem[g] == '0);
        assign rem[g+1]   = start[g] ? (REM_W'(span[g]) - REM_W'(1))
                                     : (rem[g] - REM_W'(1));
        assign len[g*LEN_W +: LEN_W] = start[g] ? code[g] : '0;
        assign ends_here[g] = start[g] && ((g + int'(span[g])) <= PARCELS);
    end

    always_comb begin
        done_cnt = '0;
        for (int i = 0; i < PARCELS; i++) begin
            done_cnt = done_cnt + CNT_W'(ends_here[i]);
        end
    end

    assign carry      = rem[PARCELS][1:0];
    assign unused_rem = ^rem[PARCELS][REM_W-1:2];
endmodule

// File: rtl/vl_boundary_marker.sv
module vl_boundary_marker #(
    parameter  int PARCELS  = 16,
    parameter  int PARCEL_W = 16,
    localparam int LINE_W   = PARCELS * PARCEL_W,
    localparam int IDX_W    = $clog2(PARCELS),
    localparam int CNT_W    = $clog2(PARCELS + 1),
    localparam int LEN_W    = vlbm_pkg::LEN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LINE_W-1:0]        in_line,
    input  logic                     in_flush,
    input  logic [IDX_W-1:0]         in_offset,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [PARCELS-1:0]       out_start,
    output logic [PARCELS*LEN_W-1:0] out_len,
    output logic [CNT_W-1:0]         out_count,
    output logic [1:0]               out_tail
);
    typedef struct packed {
        logic                     valid;
        logic [PARCELS-1:0]       start;
        logic [PARCELS*LEN_W-1:0] len;
        logic [CNT_W-1:0]         cnt;
        logic [1:0]               tail;
        logic [1:0]               carry;
    } state_t;

    state_t cur_q, nxt_d;

    logic [LEN_W-1:0]         code_w [PARCELS];
    logic [2:0]               span_w [PARCELS];
    logic [IDX_W:0]           skip_w;
    logic [PARCELS-1:0]       scan_start;
    logic [PARCELS*LEN_W-1:0] scan_len;
    logic [CNT_W-1:0]         scan_cnt;
    logic [1:0]               scan_carry;
    logic                     accept_w;
    logic [1:0]               tail_w;

    for (genvar g = 0; g < PARCELS; g++) begin : g_head
        vlbm_parcel_len #(.PARCEL_W(PARCEL_W)) u_len (
            .parcel (in_line[g*PARCEL_W +: PARCEL_W]),
            .code   (code_w[g]),
            .span   (span_w[g])
        );
    end

    assign skip_w = in_flush ? (IDX_W+1)'(in_offset) : (IDX_W+1)'(cur_q.carry);

    vlbm_scan #(.PARCELS(PARCELS)) u_scan (
        .code     (code_w),
        .span     (span_w),
        .skip     (skip_w),
        .start    (scan_start),
        .len      (scan_len),
        .done_cnt (scan_cnt),
        .carry    (scan_carry)
    );

    assign in_ready = !cur_q.valid || out_ready;
    assign accept_w = in_valid && in_ready;
    assign tail_w   = in_flush ? 2'd0 : cur_q.carry;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.valid && out_ready) nxt_d.valid = 1'b0;
        if (accept_w) begin
            nxt_d.valid = 1'b1;
            nxt_d.start = scan_start;
            nxt_d.len   = scan_len;
            nxt_d.tail  = tail_w;
            nxt_d.cnt   = scan_cnt + CNT_W'(tail_w != 2'd0);
            nxt_d.carry = scan_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.valid;
    assign out_start = cur_q.start;
    assign out_len   = cur_q.len;
    assign out_count = cur_q.cnt;
    assign out_tail  = cur_q.tail;
endmodule

// File: rtl/vlbm_chk.sv
module vlbm_chk #(
    parameter  int PARCELS = 16,
    localparam int IDX_W   = $clog2(PARCELS),
    localparam int CNT_W   = $clog2(PARCELS + 1),
    localparam int LEN_W   = vlbm_pkg::LEN_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     in_flush,
    input logic [IDX_W-1:0]         in_offset,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [PARCELS-1:0]       out_start,
    input logic [PARCELS*LEN_W-1:0] out_len,
    input logic [CNT_W-1:0]         out_count,
    input logic [1:0]               out_tail
);
    logic [IDX_W-1:0]   off_q;
    logic [PARCELS-1:0] below_off;
    logic [PARCELS-1:0] below_tail;
    logic               stray_len;

    always_ff @(posedge clk) off_q <= in_offset;

    always_comb begin
        below_off  = (PARCELS'(1) << off_q) - PARCELS'(1);
        below_tail = (PARCELS'(1) << out_tail) - PARCELS'(1);
        stray_len  = 1'b0;
        for (int i = 0; i < PARCELS; i++) begin
            if (!out_start[i] && (out_len[i*LEN_W +: LEN_W] != '0)) stray_len = 1'b1;
        end
    end

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_start) && $stable(out_len)
                                    && $stable(out_count) && $stable(out_tail)); // R7
    AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R7
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9
    AST_REDIRECT_START: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_flush |=> out_start[off_q] && (out_tail == 2'd0)
                                             && ((out_start & below_off) == '0)); // R6
    AST_TAIL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_tail != 2'd0) |-> out_start[out_tail]
                                            && ((out_start & below_tail) == '0)); // R5
    AST_LEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !stray_len); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> 32'(out_count) <= $countones(out_start) + 32'(out_tail != 2'd0)); // R4
endmodule

bind vl_boundary_marker vlbm_chk #(.PARCELS(PARCELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_flush  (in_flush),
    .in_offset (in_offset),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_start (out_start),
    .out_len   (out_len),
    .out_count (out_count),
    .out_tail  (out_tail)
);

// File: tb/vl_boundary_marker_bench.sv
`timescale 1ns/1ps
module vl_boundary_marker_bench;
    localparam int P  = 16;
    localparam int NL = 96;
    localparam int NS = NL * P + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [P*16-1:0] in_line = '0;
    logic          in_flush = 1'b0;
    logic [3:0]    in_offset = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [P-1:0]  out_start;
    logic [P*3-1:0] out_len;
    logic [4:0]    out_count;
    logic [1:0]    out_tail;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0]    strm  [NS];
    logic [P-1:0]   es    [NL];
    logic [P*3-1:0] el    [NL];
    int             ecnt  [NL];
    int             etail [NL];
    bit             fl    [NL];
    int             off   [NL];

    always #2 clk = ~clk;

    vl_boundary_marker u_vl_boundary_marker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_flush(in_flush), .in_offset(in_offset),
        .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
        .out_len(out_len), .out_count(out_count), .out_tail(out_tail)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Build the stream from a list of instructions; expectations follow from the list.
    task automatic build_stream();
        int pos;
        pos = 0;
        for (int i = 0; i < NS; i++) strm[i] = 16'($urandom());
        for (int L = 0; L < NL; L++) begin
            es[L] = '0; el[L] = '0; ecnt[L] = 0;
            fl[L]  = (L % 4 == 3);
            off[L] = (L / 4) % 16;
        end
        for (int L = 0; L < NL; L++) begin
            int base;
            base = L * P;
            if (fl[L]) begin
                etail[L] = 0;
                for (int j = 0; j < off[L]; j++) strm[base + j] = 16'hFFFF;
                pos = base + off[L];
            end else begin
                etail[L] = (pos > base) ? pos - base : 0;
            end
            while (pos < base + P) begin
                int t, n, code, endl;
                t = int'($urandom() % 8);
                if (t <= 1)      begin n = 1; code = 0; end
                else if (t <= 4) begin n = 2; code = 1; end
                else if (t == 5) begin n = 3; code = 2; end
                else if (t == 6) begin n = 4; code = 3; end
                else             begin n = 1; code = 4; end
                if (t == 7) strm[pos] = 16'($urandom()) | 16'h007F;
                else        strm[pos] = (16'($urandom()) << (t + 1)) | 16'((1 << t) - 1);
                es[L][pos - base] = 1'b1;
                el[L][(pos - base)*3 +: 3] = 3'(code);
                endl = (pos + n - 1) / P;
                if (endl == L) ecnt[L]++;
                else if (endl < NL && !fl[endl]) ecnt[endl]++;
                pos = pos + n;
            end
        end
    endtask

    initial begin
        build_stream();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R8 in_ready after reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle after release", 64'(out_valid), 64'd0);
        for (int L = 0; L < NL; L++) begin
            for (int i = 0; i < P; i++) in_line[i*16 +: 16] = strm[L*P + i];
            in_flush  = fl[L];
            in_offset = 4'(off[L]);
            in_valid  = 1'b1;
            if (L % 7 == 3) begin
                out_ready = 1'b0;
                repeat (3) begin
                    @(posedge clk); @(negedge clk);
                    chk("R7 in_ready low while held", 64'(in_ready), 64'd0);
                    chk("R7 out_valid held", 64'(out_valid), 64'd1);
                    chk("R7 start flags held", 64'(out_start), 64'(es[L-1]));
                    chk("R7 count held", 64'(out_count), 64'(ecnt[L-1]));
                end
                out_ready = 1'b1;
            end
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            chk("R9 out_valid after accept", 64'(out_valid), 64'd1);
            if (L == 0)     chk("R2 start flags first line", 64'(out_start), 64'(es[L]));
            else if (fl[L]) chk("R6 start flags redirect line", 64'(out_start), 64'(es[L]));
            else            chk("R3 start flags", 64'(out_start), 64'(es[L]));
            chk("R1 length codes", 64'(out_len), 64'(el[L]));
            chk("R4 complete count", 64'(out_count), 64'(ecnt[L]));
            if (fl[L]) chk("R6 tail cleared on redirect", 64'(out_tail), 64'(etail[L]));
            else       chk("R5 carried tail parcels", 64'(out_tail), 64'(etail[L]));
        end
        @(posedge clk); @(negedge clk);
        chk("R7 result drained", 64'(out_valid), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule